// File: doc/BRIEF.md
# MSI Message Ring Writer

This block takes message-signalled interrupts from an I/O fabric and turns each one into a 16-byte record. It writes that record into a circular buffer that lives in host memory, and it raises a level interrupt to the processor. Software programs where the ring sits (a 64-bit base), picks the ring size from four powers of two, and consumes records by moving a read offset. The block keeps the write offset. That offset counts upward without wrapping, so software must mask it to the ring size before it compares or indexes.

A single memory beat carries each record. The beat uses a valid/ready master handshake. The 32-bit message word sits in the lowest four bytes in little-endian byte order, and the remaining twelve bytes are zero. When the ring has no free slot, the block can set a sticky status flag. It can also either hold off the fabric until space frees or throw the message away. While the block is disabled, messages are taken and discarded.

Top module: `msi_ring_writer`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, `mem_valid` is low and `msi_ready` is high.
- R2: Register addresses are 0 = control, 3 = base upper 32 bits, 4 = base lower 32 bits, 5 = read offset, 6 = write offset. Control bits are: bit 0 enable, bit 1 full detection, bit 3 interrupt enable, bit 4 stop-on-full, bits 9:8 size code, bit 16 sticky full (reads as status; writing 1 clears it). The write offset is read-only, and all other addresses read zero. Read data appears on `reg_rdata` one clock after the `reg_rd` strobe.
- R3: For an accepted message, one beat is issued with `mem_addr` = base + (write offset AND mask). `mem_data[31:0]` holds the message word, with byte 0 on bits 7:0, and `mem_data[127:32]` is zero.
- R4: The write offset grows by 16 on each completed beat and does not wrap at the ring size. A value written to the read offset is stored ANDed with the current mask.
- R5: The mask is 2^(15+code) − 16 for size codes 0 to 3 (32 KB to 256 KB), so record addresses wrap inside the ring.
- R6: `irq` is high exactly when interrupt enable is set and the masked write offset differs from the read offset. Writing the read offset to match the masked write offset clears it.
- R7: The ring is full when ((masked write offset + 16) AND mask) equals the read offset. A message that arrives while the ring is full and enabled, with full detection on, sets the sticky full bit.
- R8: With enable, full detection and stop-on-full all set, `msi_ready` is low while the ring is full. The held message is taken and written once the read offset moves.
- R9: When the ring is full and the block is not stalling, an arriving message is accepted and dropped: no beat is issued and the write offset stays the same.
- R10: While enable is clear, `msi_ready` is high, messages are discarded, and no beat is issued.
- R11: While a beat waits for `mem_ready`, `mem_valid`, `mem_addr` and `mem_data` hold steady and `msi_ready` is low.
- R12: Clearing enable and interrupt enable together stops all further record writes and drops `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| msi_valid | input | 1 | Inbound message present |
| msi_ready | output | 1 | Inbound message taken this cycle when high with valid |
| msi_data | input | 32 | Inbound message word |
| mem_valid | output | 1 | Record beat valid |
| mem_ready | input | 1 | Memory accepts beat |
| mem_addr | output | 64 | Byte address of the record |
| mem_data | output | 128 | Record contents |
| irq | output | 1 | Level interrupt to host |

## Verification
An accepted message drives `mem_valid` high one clock after the accepting edge. The write offset and `irq` change on the edge that completes the handshake, so with `mem_ready` held high a record becomes visible two edges after acceptance. A register read returns its value one edge after the strobe. The full-ring conditions act on `msi_ready` in the same cycle that the read offset register updates. The bench drives on falling edges and samples on the next falling edge after the last register in each of these paths, and it waits for the handshake edge before it reads back offsets or checks `irq`.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 64;
    localparam int OFF_W     = 32;
    localparam int BEAT_W    = 128;
    localparam int REG_AW    = 3;
    localparam int SIZE_W    = 2;
    localparam int MIN_LOG2  = 15;
    localparam int REC_BYTES = 16;
    localparam int HI_W      = ADDR_W - DATA_W;
    localparam int PAD_W     = BEAT_W - DATA_W;
    localparam int EXT_W     = ADDR_W - OFF_W;

    // control bit positions
    localparam int B_EN   = 0;
    localparam int B_FDET = 1;
    localparam int B_IE   = 3;
    localparam int B_STOP = 4;
    localparam int B_SIZE = 8;
    localparam int B_FULL = 16;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL    = 3'd0,
        RA_BASE_HI = 3'd3,
        RA_BASE_LO = 3'd4,
        RA_RD_OFF  = 3'd5,
        RA_WR_OFF  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic              stop;
        logic              ie;
        logic              fdet;
        logic              en;
    } ctrl_t;

    function automatic logic [OFF_W-1:0] ring_mask(input logic [SIZE_W-1:0] code);
        logic [OFF_W-1:0] span;
        span = {{(OFF_W-1){1'b0}}, 1'b1} << (MIN_LOG2 + int'(code));
        return (span - {{(OFF_W-1){1'b0}}, 1'b1}) & ~OFF_W'(REC_BYTES - 1);
    endfunction

endpackage

// File: rtl/msi_ring_geom.sv
module msi_ring_geom
    import msi_ring_pkg::*;
(
    input  logic [SIZE_W-1:0] size,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [OFF_W-1:0]  mask,
    output logic              full,
    output logic              pending
);
    logic [OFF_W-1:0] wr_wrap;
    logic [OFF_W-1:0] wr_next;

    always_comb begin
        mask    = ring_mask(size);
        wr_wrap = wr_off & mask;
        wr_next = (wr_wrap + OFF_W'(REC_BYTES)) & mask;
        full    = (wr_next == rd_off);
        pending = (wr_wrap != rd_off);
    end

endmodule

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
    import msi_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              full_evt,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [OFF_W-1:0]  mask,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] base,
    output logic [OFF_W-1:0]  rd_off,
    output logic              full_flag
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [ADDR_W-1:0] base;
        logic [OFF_W-1:0]  rd_off;
        logic              full;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t             q_q, q_d;
    logic [DATA_W-1:0] view_d;

    always_comb begin
        view_d = '0;
        case (reg_addr_e'(reg_addr))
            RA_CTRL: begin
                view_d[B_EN]            = q_q.ctrl.en;
                view_d[B_FDET]          = q_q.ctrl.fdet;
                view_d[B_IE]            = q_q.ctrl.ie;
                view_d[B_STOP]          = q_q.ctrl.stop;
                view_d[B_SIZE +: SIZE_W] = q_q.ctrl.size;
                view_d[B_FULL]          = q_q.full;
            end
            RA_BASE_HI: view_d = q_q.base[ADDR_W-1:DATA_W];
            RA_BASE_LO: view_d = q_q.base[DATA_W-1:0];
            RA_RD_OFF:  view_d = q_q.rd_off;
            RA_WR_OFF:  view_d = wr_off;
            default:    view_d = '0;
        endcase

        q_d = q_q;
        if (reg_wr) begin
            case (reg_addr_e'(reg_addr))
                RA_CTRL: begin
                    q_d.ctrl.en   = reg_wdata[B_EN];
                    q_d.ctrl.fdet = reg_wdata[B_FDET];
                    q_d.ctrl.ie   = reg_wdata[B_IE];
                    q_d.ctrl.stop = reg_wdata[B_STOP];
                    q_d.ctrl.size = reg_wdata[B_SIZE +: SIZE_W];
                    if (reg_wdata[B_FULL]) begin
                        q_d.full = 1'b0;
                    end
                end
                RA_BASE_HI: q_d.base[ADDR_W-1:DATA_W] = reg_wdata[HI_W-1:0];
                RA_BASE_LO: q_d.base[DATA_W-1:0]      = reg_wdata;
                RA_RD_OFF:  q_d.rd_off                = reg_wdata & mask;
                default: ;
            endcase
        end
        if (full_evt) begin
            q_d.full = 1'b1;
        end
        if (reg_rd) begin
            q_d.rdata = view_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign reg_rdata = q_q.rdata;
    assign ctrl      = q_q.ctrl;
    assign base      = q_q.base;
    assign rd_off    = q_q.rd_off;
    assign full_flag = q_q.full;

endmodule

// File: rtl/msi_ring_engine.sv
module msi_ring_engine
    import msi_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              fdet,
    input  logic              stop,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  mask,
    input  logic              full,
    input  logic              msi_valid,
    input  logic [DATA_W-1:0] msi_data,
    output logic              msi_ready,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BEAT_W-1:0] mem_data,
    output logic [OFF_W-1:0]  wr_off,
    output logic              full_evt
);
    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] data;
        logic [OFF_W-1:0]  wr_off;
    } eng_t;

    eng_t q_q, q_d;
    logic stall_d;
    logic take_d;

    always_comb begin
        stall_d   = en && (q_q.busy || (full && fdet && stop));
        msi_ready = !stall_d;
        take_d    = msi_valid && !stall_d;
        full_evt  = en && fdet && full && msi_valid;

        q_d = q_q;
        if (q_q.busy && mem_ready) begin
            q_d.busy   = 1'b0;
            q_d.wr_off = q_q.wr_off + OFF_W'(REC_BYTES);
        end
        if (take_d && en && !full) begin
            q_d.busy = 1'b1;
            q_d.addr = base + {{EXT_W{1'b0}}, q_q.wr_off & mask};
            q_d.data = {{PAD_W{1'b0}}, msi_data};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign mem_valid = q_q.busy;
    assign mem_addr  = q_q.addr;
    assign mem_data  = q_q.data;
    assign wr_off    = q_q.wr_off;

endmodule

// File: rtl/msi_ring_writer.sv
module msi_ring_writer
    import msi_ring_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          msi_valid,
    output logic          msi_ready,
    input  logic [31:0]   msi_data,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [63:0]   mem_addr,
    output logic [127:0]  mem_data,
    output logic          irq
);
    ctrl_t             ctrl_w;
    logic [ADDR_W-1:0] base_w;
    logic [OFF_W-1:0]  rd_off_w;
    logic [OFF_W-1:0]  wr_off_w;
    logic [OFF_W-1:0]  mask_w;
    logic              full_w;
    logic              pending_w;
    logic              full_evt_w;
    logic              full_flag_w;

    msi_ring_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .full_evt  (full_evt_w),
        .wr_off    (wr_off_w),
        .mask      (mask_w),
        .ctrl      (ctrl_w),
        .base      (base_w),
        .rd_off    (rd_off_w),
        .full_flag (full_flag_w)
    );

    msi_ring_geom geom_i (
        .size    (ctrl_w.size),
        .wr_off  (wr_off_w),
        .rd_off  (rd_off_w),
        .mask    (mask_w),
        .full    (full_w),
        .pending (pending_w)
    );

    msi_ring_engine eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_w.en),
        .fdet      (ctrl_w.fdet),
        .stop      (ctrl_w.stop),
        .base      (base_w),
        .mask      (mask_w),
        .full      (full_w),
        .msi_valid (msi_valid),
        .msi_data  (msi_data),
        .msi_ready (msi_ready),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .wr_off    (wr_off_w),
        .full_evt  (full_evt_w)
    );

    assign irq = ctrl_w.ie && pending_w;

endmodule

// File: rtl/msi_ring_chk.sv
module msi_ring_chk
    import msi_ring_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              fdet,
    input logic              stop,
    input logic [SIZE_W-1:0] size,
    input logic [ADDR_W-1:0] base,
    input logic              msi_valid,
    input logic              msi_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BEAT_W-1:0] mem_data,
    input logic [OFF_W-1:0]  wr_off,
    input logic              full
);
    logic [ADDR_W-1:0] rel;
    assign rel = mem_addr - base;

    // R11: a waiting beat holds its payload
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    // R4: completed beat advances the write offset by one record
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> wr_off == $past(wr_off) + 32'd16);

    // R4: without a completed beat the write offset does not move
    p_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid && mem_ready) |=> $stable(wr_off));

    // R3: padding bytes of a record are zero
    p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_data[BEAT_W-1:DATA_W] == '0);

    // R5: a new beat lands aligned and inside the ring
    p_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid) && $stable(base) && $stable(size) |->
            rel[3:0] == 4'd0 && rel < (64'd1 << (6'd15 + {4'd0, size})));

    // R10 / R12: messages taken while disabled start no beat
    p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en && msi_valid && !mem_valid |=> !mem_valid);

    // R8: stalling on a full ring
    p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en && fdet && stop && full |-> !msi_ready);

    // R9: a message taken into a full ring starts no beat
    p_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en && full && msi_valid && msi_ready && !mem_valid |=> !mem_valid);

endmodule

bind msi_ring_writer msi_ring_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl_w.en),
    .fdet      (ctrl_w.fdet),
    .stop      (ctrl_w.stop),
    .size      (ctrl_w.size),
    .base      (base_w),
    .msi_valid (msi_valid),
    .msi_ready (msi_ready),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .wr_off    (wr_off_w),
    .full      (full_w)
);

// File: tb/msi_ring_writer_tb_top.sv
module msi_ring_writer_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic         reg_rd = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         msi_valid = 1'b0;
    logic         msi_ready;
    logic [31:0]  msi_data = '0;
    logic         mem_valid;
    logic         mem_ready = 1'b1;
    logic [63:0]  mem_addr;
    logic [127:0] mem_data;
    logic         irq;

    int           n_chk = 0;
    int           n_fail = 0;
    int           beats = 0;
    logic [63:0]  last_addr = '0;
    logic [127:0] last_data = '0;

    localparam logic [63:0] BASE = 64'h0000_0001_8000_0000;
    localparam logic [31:0] VEC_MSI [6] = '{32'h0000_0001, 32'h0000_BEEF, 32'hFFFF_ABCD,
                                            32'h1234_5678, 32'h8000_0000, 32'h0000_FFFF};
    localparam logic [31:0] VEC_OFF [6] = '{32'h00, 32'h10, 32'h20, 32'h30, 32'h40, 32'h50};

    always #2.5 clk = ~clk;

    msi_ring_writer dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_valid(msi_valid),
        .msi_ready(msi_ready), .msi_data(msi_data), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
    );

    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            beats     <= beats + 1;
            last_addr <= mem_addr;
            last_data <= mem_data;
        end
    end

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk); msi_valid = 1'b1; msi_data = w;
        while (!msi_ready) @(negedge clk);
        @(negedge clk); msi_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int          b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1", "irq", irq, 0);
        chk("R1", "mem_valid", mem_valid, 0);
        chk("R1", "msi_ready", msi_ready, 1);
        rd_reg(3'd0, v); chk("R1", "ctrl", v, 0);
        rd_reg(3'd6, v); chk("R1", "wr_off", v, 0);
        rd_reg(3'd4, v); chk("R1", "base_lo", v, 0);

        // R10 disabled: accepted and discarded
        send(32'h0000_1234);
        idle(3);
        chk("R10", "beats while disabled", beats, 0);
        rd_reg(3'd6, v); chk("R10", "wr_off while disabled", v, 0);

        // R2 register map
        wr_reg(3'd3, BASE[63:32]);
        wr_reg(3'd4, BASE[31:0]);
        rd_reg(3'd3, v); chk("R2", "base_hi", v, BASE[63:32]);
        rd_reg(3'd4, v); chk("R2", "base_lo", v, BASE[31:0]);
        rd_reg(3'd1, v); chk("R2", "unmapped", v, 0);
        wr_reg(3'd6, 32'h40);
        rd_reg(3'd6, v); chk("R2", "wr_off read-only", v, 0);
        wr_reg(3'd0, 32'h0000_000B);
        rd_reg(3'd0, v); chk("R2", "ctrl readback", v, 32'h0000_000B);

        // R3 R4 R6 vector table
        for (int i = 0; i < 6; i++) begin
            send(VEC_MSI[i]);
            idle(1);
            chk("R3", "record addr", last_addr, BASE + {32'd0, VEC_OFF[i]});
            chk("R3", "record data", last_data, {96'd0, VEC_MSI[i]});
            rd_reg(3'd6, v); chk("R4", "wr_off step", v, VEC_OFF[i] + 32'h10);
            chk("R6", "irq pending", irq, 1);
        end
        chk("R3", "beat count", beats, 6);

        // R6 clear by read offset, R4 masking
        wr_reg(3'd5, 32'h60);
        chk("R6", "irq cleared", irq, 0);
        wr_reg(3'd5, 32'h0001_2345);
        rd_reg(3'd5, v); chk("R4", "rd_off masked", v, 32'h2340);
        chk("R6", "irq mismatch", irq, 1);
        wr_reg(3'd0, 32'h0000_0003);
        chk("R6", "irq with ie off", irq, 0);
        wr_reg(3'd0, 32'h0000_000B);
        wr_reg(3'd5, 32'h60);

        // R11 memory backpressure
        mem_ready = 1'b0;
        send(32'h0000_0077);
        idle(3);
        chk("R11", "mem_valid held", mem_valid, 1);
        chk("R11", "msi_ready low", msi_ready, 0);
        chk("R11", "addr held", mem_addr, BASE + 64'h60);
        rd_reg(3'd6, v); chk("R11", "wr_off waits", v, 32'h60);
        mem_ready = 1'b1;
        idle(1);
        chk("R11", "beat after ready", last_data, {96'd0, 32'h77});
        wr_reg(3'd5, 32'h70);

        // R7 R8 full with stop
        wr_reg(3'd5, 32'h80);
        wr_reg(3'd0, 32'h0000_001B);
        chk("R8", "ready low when full", msi_ready, 0);
        b0 = beats;
        @(negedge clk); msi_valid = 1'b1; msi_data = 32'h0000_0099;
        idle(3);
        chk("R8", "still stalled", msi_ready, 0);
        chk("R8", "no beat while stalled", beats, b0);
        msi_valid = 1'b1;
        wr_reg(3'd5, 32'h70);
        @(negedge clk); msi_valid = 1'b0;
        idle(1);
        chk("R8", "resumed beat addr", last_addr, BASE + 64'h70);
        chk("R8", "resumed beat data", last_data, {96'd0, 32'h99});
        rd_reg(3'd0, v); chk("R7", "sticky full set", v, 32'h0001_001B);
        wr_reg(3'd0, 32'h0001_000B);
        rd_reg(3'd0, v); chk("R7", "sticky full cleared", v, 32'h0000_000B);

        // R9 full without stop drops
        wr_reg(3'd5, 32'h90);
        chk("R9", "ready when full no stop", msi_ready, 1);
        b0 = beats;
        send(32'h0000_00AA);
        idle(2);
        chk("R9", "no beat", beats, b0);
        rd_reg(3'd6, v); chk("R9", "wr_off unchanged", v, 32'h80);
        rd_reg(3'd0, v); chk("R7", "sticky on drop", v, 32'h0001_000B);
        wr_reg(3'd0, 32'h0001_000B);

        // R5 R4 wrap at 32 KB, write offset unwrapped
        wr_reg(3'd5, 32'h70);
        for (int i = 0; i < 2042; i++) begin
            send(i[31:0]);
        end
        idle(2);
        chk("R5", "wrapped addr", last_addr, BASE + 64'h10);
        rd_reg(3'd6, v); chk("R4", "wr_off unwrapped", v, 32'h8020);

        // R5 size code 3
        wr_reg(3'd0, 32'h0000_030B);
        wr_reg(3'd5, 32'h8020);
        chk("R6", "irq with wide mask", irq, 0);
        send(32'h0000_0042);
        idle(1);
        chk("R5", "256KB addr", last_addr, BASE + 64'h8020);

        // R12 shutdown
        wr_reg(3'd0, 32'h0000_0000);
        chk("R12", "irq off", irq, 0);
        b0 = beats;
        send(32'h0000_00BB);
        idle(3);
        chk("R12", "no beat after shutdown", beats, b0);
        rd_reg(3'd6, v); chk("R12", "wr_off kept", v, 32'h8030);

        finish_run();
    end

endmodule